// File: doc/BRIEF.md
# PLL Divider and Test Routing Core

This block is the digital heart of a frequency synthesizer loop. A reference divider brings the crystal rate down by 64, 80 or 128, which a two-bit select picks. A programmable main counter divides the prescaled oscillator rate by a 15-bit ratio. A phase-frequency detector compares the two divided strobes and drives up/down requests to an external charge pump. A lock detector watches how wide those requests are and raises a lock flag once the loop has settled. The block also gates the tuning amplifier output, passes the pump current select through, and lets a three-bit test code route the internal strobes onto two of the four band-switch pins.

The whole core runs on one system clock. The crystal and oscillator rates arrive as single-cycle enable strobes (`xtal_tick`, `vco_tick`), so the block has no clock crossings. Each divider samples its ratio only at its own terminal count. A ratio written by the host therefore takes effect on the next divided period and never cuts the current period short.

Top module: `pll_divider_core`

## Requirements
- R1: The reference strobe repeats every 80 `xtal_tick` pulses when `rs_b`=0 (whatever `rs_a` is), every 64 when `rs_a`=1 and `rs_b`=1, and every 128 when `rs_a`=0 and `rs_b`=1.
- R2: The divided strobe repeats every `ratio_n` `vco_tick` pulses, for any `ratio_n` from 1024 to 32767.
- R3: A change of the reference select or of `ratio_n` in the middle of a period leaves that period at its old length; the following period has the new length.
- R4: With `test_code`=3'b100, `band_out[3]` carries the reference strobe and `band_out[1]` the divided strobe, while `band_out[2]` and `band_out[0]` follow `band_reg[2]` and `band_reg[0]`.
- R5: With `test_code`=3'b101, `band_out[3]` carries the reference strobe and `band_out[1]` toggles on every divided strobe, giving half the divided rate.
- R6: For any other `test_code` (3'b001 is normal operation), `band_out` equals `band_reg`.
- R7: With `test_code`=3'b000, the phase detector takes `ext_ref` and `ext_div` as its inputs, and the internal strobes have no effect on `pump_up` or `pump_dn`.
- R8: A reference strobe that arrives before the divided strobe raises `pump_up` from the next cycle until the cycle after the divided strobe. The opposite order raises `pump_dn` in the same way. Coincident strobes raise neither, and the two pump outputs are never high together.
- R9: `lock` (1 = locked, 0 = unlocked) goes to 1 after four consecutive reference periods in which no pump pulse lasts 2 or more cycles.
- R10: `lock` drops to 0 in the cycle after a pump pulse reaches a width of 2 cycles.
- R11: `tune_en` is low while `os`=1 and high while `os`=0; `cp_hi` follows `cp`.
- R12: While `rst_n` is low and at its release, `pump_up`, `pump_dn` and `lock` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xtal_tick | input | 1 | One-cycle strobe per crystal period |
| vco_tick | input | 1 | One-cycle strobe per prescaled oscillator period |
| ratio_n | input | 15 | Main counter ratio |
| rs_a | input | 1 | Reference select, low bit |
| rs_b | input | 1 | Reference select, high bit |
| test_code | input | 3 | Test routing code |
| band_reg | input | 4 | Band-switch register contents |
| os | input | 1 | 1 switches the tuning amplifier off |
| cp | input | 1 | Pump current select |
| ext_ref | input | 1 | External reference strobe for phase test |
| ext_div | input | 1 | External compare strobe for phase test |
| band_out | output | 4 | Band-switch pin drive |
| pump_up | output | 1 | Charge pump up request |
| pump_dn | output | 1 | Charge pump down request |
| lock | output | 1 | Lock flag |
| tune_en | output | 1 | Tuning amplifier enable |
| cp_hi | output | 1 | High pump current select |

## Verification
The dividers are tried with every reference select code, including both codes that map to 80, and with several main ratios. Period measurements on the routed pins are what separate a wrong ratio decode from a wrong reload. Ratios changed partway through a period show whether the dividers reload only at the boundary. The phase detector is driven through the external strobes in all three orders: reference first, divided first, and coincident. A loop run with phase-aligned ticks that then skips a few oscillator ticks shows both the lock build-up and the clear on a wide pulse.

// File: rtl/pll_divider_core_pkg.sv
// Shared constants for the PLL divider core: test routing codes and
// the reference ratio selection.
package pll_divider_core_pkg;

    localparam logic [2:0] TM_PHASE    = 3'b000;
    localparam logic [2:0] TM_NORMAL   = 3'b001;
    localparam logic [2:0] TM_REF_DIV  = 3'b100;
    localparam logic [2:0] TM_REF_HALF = 3'b101;

    typedef enum logic [1:0] {
        RSEL_FAST = 2'd0,
        RSEL_MID  = 2'd1,
        RSEL_SLOW = 2'd2
    } rsel_e;

    // Decode the two select bits; the low bit only matters when the high bit is set.
    function automatic rsel_e decode_rsel(input logic sel_a, input logic sel_b);
        if (!sel_b)     return RSEL_MID;
        else if (sel_a) return RSEL_FAST;
        else            return RSEL_SLOW;
    endfunction

endpackage

// File: rtl/tick_divider.sv
// Programmable divider over an enable strobe.
// Counts down on each tick and emits a one-cycle strobe on the tick that ends a
// period. The ratio is sampled only at that terminal tick, so a new ratio
// applies from the next period on. Assumes ratio >= 2 in use; 0 and 1 give a
// strobe on every tick.
module tick_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] ratio,
    output logic         strobe
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] remain;

    // Count down per tick; reload and strobe at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (tick) begin
                if (remain <= ONE) begin
                    remain <= ratio;
                    strobe <= 1'b1;
                end else begin
                    remain <= remain - ONE;
                end
            end
        end
    end

    // R1, R2: a strobe only ever follows a tick.
    assert_strobe_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> $past(tick));

    // R3: the counter never holds more than the ratio it last loaded.
    assert_reload_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && remain <= ONE) |=> (remain == $past(ratio)));

endmodule

// File: rtl/phase_detector.sv
// Three-state phase-frequency detector on single-cycle strobes.
// A strobe sets its own request; when both requests would be set, both clear.
// Assumes each input is a one-cycle pulse.
module phase_detector (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_s,
    input  logic div_s,
    output logic up,
    output logic dn
);

    logic up_next;
    logic dn_next;

    // Candidate request state before the mutual clear.
    always_comb begin
        up_next = up | ref_s;
        dn_next = dn | div_s;
    end

    // Register requests, clearing both when both are pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else if (up_next && dn_next) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else begin
            up <= up_next;
            dn <= dn_next;
        end
    end

    assert_no_dual_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && dn));

    assert_lead_raises_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_s && !div_s && !dn) |=> up);

endmodule

// File: rtl/lock_detector.sv
// Lock flag from pump pulse widths.
// Each reference period is good when no up/down pulse reaches LOCK_WIDTH
// cycles. LOCK_PERIODS good periods in a row set the flag; a pulse that
// reaches LOCK_WIDTH clears it at once. Assumes ref_s is a one-cycle strobe.
module lock_detector #(
    parameter int LOCK_PERIODS = 4,
    parameter int LOCK_WIDTH   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_s,
    input  logic up,
    input  logic dn,
    output logic lock
);

    localparam int WW = $clog2(LOCK_WIDTH + 1);
    localparam int GW = $clog2(LOCK_PERIODS + 1);
    localparam logic [WW-1:0] W_MAX  = WW'(LOCK_WIDTH);
    localparam logic [WW-1:0] W_TRIP = WW'(LOCK_WIDTH - 1);
    localparam logic [GW-1:0] G_LAST = GW'(LOCK_PERIODS - 1);

    logic          active;
    logic          wide;
    logic [WW-1:0] width_cnt;
    logic [GW-1:0] good_cnt;
    logic          bad_seen;

    // Pulse is wide once it is in its LOCK_WIDTH-th cycle.
    always_comb begin
        active = up | dn;
        wide   = active && (width_cnt >= W_TRIP);
    end

    // Measure the current pulse width, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                 width_cnt <= '0;
        else if (!active)           width_cnt <= '0;
        else if (width_cnt != W_MAX) width_cnt <= width_cnt + WW'(1);
    end

    // Grade each reference period and update the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good_cnt <= '0;
            bad_seen <= 1'b0;
            lock     <= 1'b0;
        end else begin
            if (ref_s) begin
                bad_seen <= 1'b0;
                if (bad_seen || wide) begin
                    good_cnt <= '0;
                end else if (good_cnt >= G_LAST) begin
                    good_cnt <= G_LAST;
                    lock     <= 1'b1;
                end else begin
                    good_cnt <= good_cnt + GW'(1);
                end
            end else if (wide) begin
                bad_seen <= 1'b1;
            end
            if (wide) lock <= 1'b0;
        end
    end

    assert_lock_rises_on_ref_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(ref_s));

    assert_wide_clears_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((up || dn) && $past(up || dn)) |=> !lock);

endmodule

// File: rtl/test_router.sv
// Band pin routing for test codes.
// Normal codes pass the band register through. The reference/divided codes
// put the reference strobe on pin 3 and the divided strobe (or its half-rate
// toggle) on pin 1. Assumes div_s is a one-cycle strobe.
module test_router
    import pll_divider_core_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] code,
    input  logic [3:0] band_reg,
    input  logic       ref_s,
    input  logic       div_s,
    output logic [3:0] band_out
);

    logic half_q;

    // Toggle once per divided strobe for the half-rate view.
    always_ff @(posedge clk) begin
        if (!rst_n)     half_q <= 1'b0;
        else if (div_s) half_q <= ~half_q;
    end

    // Choose what drives each band pin.
    always_comb begin
        band_out = band_reg;
        case (code)
            TM_REF_DIV: begin
                band_out[3] = ref_s;
                band_out[1] = div_s;
            end
            TM_REF_HALF: begin
                band_out[3] = ref_s;
                band_out[1] = half_q;
            end
            default: band_out = band_reg;
        endcase
    end

    assert_half_toggles_on_div_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (half_q != $past(half_q)) |-> $past(div_s));

endmodule

// File: rtl/pll_divider_core.sv
// Top of the PLL divider core.
// Selects the reference ratio, runs both dividers, chooses the comparator
// inputs (external in phase test), detects phase and lock, and routes band
// pins. Assumes xtal_tick and vco_tick are one-cycle enables on clk.
module pll_divider_core
    import pll_divider_core_pkg::*;
#(
    parameter int REF_W        = 8,
    parameter int N_W          = 15,
    parameter int RATIO_FAST   = 64,
    parameter int RATIO_MID    = 80,
    parameter int RATIO_SLOW   = 128,
    parameter int LOCK_PERIODS = 4,
    parameter int LOCK_WIDTH   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           xtal_tick,
    input  logic           vco_tick,
    input  logic [N_W-1:0] ratio_n,
    input  logic           rs_a,
    input  logic           rs_b,
    input  logic [2:0]     test_code,
    input  logic [3:0]     band_reg,
    input  logic           os,
    input  logic           cp,
    input  logic           ext_ref,
    input  logic           ext_div,
    output logic [3:0]     band_out,
    output logic           pump_up,
    output logic           pump_dn,
    output logic           lock,
    output logic           tune_en,
    output logic           cp_hi
);

    logic [REF_W-1:0] ref_ratio;
    logic             ref_s;
    logic             div_s;
    logic             phase_test;
    logic             cmp_ref;
    logic             cmp_div;

    // Map the select bits to a reference ratio.
    always_comb begin
        case (decode_rsel(rs_a, rs_b))
            RSEL_FAST: ref_ratio = REF_W'(RATIO_FAST);
            RSEL_SLOW: ref_ratio = REF_W'(RATIO_SLOW);
            default:   ref_ratio = REF_W'(RATIO_MID);
        endcase
    end

    // Comparator inputs: external strobes in phase test, internal otherwise.
    always_comb begin
        phase_test = (test_code == TM_PHASE);
        cmp_ref    = phase_test ? ext_ref : ref_s;
        cmp_div    = phase_test ? ext_div : div_s;
    end

    // Pass-through control outputs.
    always_comb begin
        tune_en = ~os;
        cp_hi   = cp;
    end

    tick_divider #(.W(REF_W)) u_ref_div (
        .clk(clk), .rst_n(rst_n), .tick(xtal_tick), .ratio(ref_ratio), .strobe(ref_s)
    );

    tick_divider #(.W(N_W)) u_main_div (
        .clk(clk), .rst_n(rst_n), .tick(vco_tick), .ratio(ratio_n), .strobe(div_s)
    );

    phase_detector u_pfd (
        .clk(clk), .rst_n(rst_n), .ref_s(cmp_ref), .div_s(cmp_div),
        .up(pump_up), .dn(pump_dn)
    );

    lock_detector #(.LOCK_PERIODS(LOCK_PERIODS), .LOCK_WIDTH(LOCK_WIDTH)) u_lock (
        .clk(clk), .rst_n(rst_n), .ref_s(cmp_ref), .up(pump_up), .dn(pump_dn),
        .lock(lock)
    );

    test_router u_route (
        .clk(clk), .rst_n(rst_n), .code(test_code), .band_reg(band_reg),
        .ref_s(ref_s), .div_s(div_s), .band_out(band_out)
    );

    // R7: in phase test with no external strobes, an idle detector stays idle.
    assert_phase_test_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (test_code == TM_PHASE && !ext_ref && !ext_div && !pump_up && !pump_dn)
        |=> (!pump_up && !pump_dn));

    // R12: reset leaves the pump and lock outputs cleared.
    assert_reset_clears_R12: assert property (@(posedge clk)
        !rst_n |=> (!pump_up && !pump_dn && !lock));

endmodule

// File: tb/test_pll_divider_core.sv
module test_pll_divider_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xtal_tick = 1'b0;
    logic        vco_tick = 1'b0;
    logic [14:0] ratio_n = 15'd1024;
    logic        rs_a = 1'b1;
    logic        rs_b = 1'b1;
    logic [2:0]  test_code = 3'b001;
    logic [3:0]  band_reg = 4'b0110;
    logic        os = 1'b0;
    logic        cp = 1'b0;
    logic        ext_ref = 1'b0;
    logic        ext_div = 1'b0;
    logic [3:0]  band_out;
    logic        pump_up;
    logic        pump_dn;
    logic        lock;
    logic        tune_en;
    logic        cp_hi;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pll_divider_core i_pll_divider_core (
        .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .vco_tick(vco_tick),
        .ratio_n(ratio_n), .rs_a(rs_a), .rs_b(rs_b), .test_code(test_code),
        .band_reg(band_reg), .os(os), .cp(cp), .ext_ref(ext_ref), .ext_div(ext_div),
        .band_out(band_out), .pump_up(pump_up), .pump_dn(pump_dn), .lock(lock),
        .tune_en(tune_en), .cp_hi(cp_hi)
    );

    typedef struct packed {
        logic [1:0]  rs;     // {rs_a, rs_b}
        logic [2:0]  code;
        logic [14:0] n;
        logic [1:0]  pin;
        logic [16:0] expect_p;
    } vec_t;

    // Period vectors: xtal_tick and vco_tick held high, so periods are in cycles.
    localparam vec_t VEC [8] = '{
        '{2'b11, 3'b100, 15'd1024, 2'd3, 17'd64},    // R1 fast
        '{2'b01, 3'b100, 15'd1024, 2'd3, 17'd128},   // R1 slow
        '{2'b00, 3'b100, 15'd1024, 2'd3, 17'd80},    // R1 mid
        '{2'b10, 3'b100, 15'd1024, 2'd3, 17'd80},    // R1 mid, low bit ignored
        '{2'b11, 3'b100, 15'd1024, 2'd1, 17'd1024},  // R2, R4 divided strobe
        '{2'b11, 3'b100, 15'd1500, 2'd1, 17'd1500},  // R2, R4
        '{2'b11, 3'b101, 15'd1024, 2'd1, 17'd2048},  // R5 half rate
        '{2'b11, 3'b101, 15'd1500, 2'd3, 17'd64}     // R5 reference on pin 3
    };

    task automatic chk(input string tag, input int act, input int exp_v);
        compared++;
        if (act != exp_v) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic wait_rise(input int idx, output int n);
        logic prev;
        prev = band_out[idx];
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (band_out[idx] && !prev) break;
            prev = band_out[idx];
            if (n > 70000) break;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int per;
        int skip;
        bit saw_up;

        // R12 reset state, R6 normal routing
        repeat (3) @(negedge clk);
        chk("R12 pump_up in reset", int'(pump_up), 0);
        chk("R12 lock in reset", int'(lock), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 pump_dn after release", int'(pump_dn), 0);
        chk("R6 band pass in 001", int'(band_out), 6);

        // Table walk: dividers and routing
        xtal_tick = 1'b1;
        vco_tick  = 1'b1;
        foreach (VEC[i]) begin
            {rs_a, rs_b} = VEC[i].rs;
            test_code    = VEC[i].code;
            ratio_n      = VEC[i].n;
            wait_rise(int'(VEC[i].pin), per);
            wait_rise(int'(VEC[i].pin), per);
            wait_rise(int'(VEC[i].pin), per);
            chk($sformatf("R1/R2/R4/R5 vector %0d period", i), per, int'(VEC[i].expect_p));
            chk($sformatf("R4/R5 vector %0d pin 2 follows register", i),
                int'(band_out[2]), int'(band_reg[2]));
        end

        // R3: mid-period change of reference select
        test_code = 3'b100;
        {rs_a, rs_b} = 2'b11;
        ratio_n = 15'd1024;
        wait_rise(3, per);
        wait_rise(3, per);
        repeat (10) @(negedge clk);
        {rs_a, rs_b} = 2'b01;
        wait_rise(3, per);
        chk("R3 reference period keeps old ratio", per + 10, 64);
        wait_rise(3, per);
        chk("R3 reference period uses new ratio", per, 128);

        // R3: mid-period change of main ratio
        wait_rise(1, per);
        repeat (10) @(negedge clk);
        ratio_n = 15'd1100;
        wait_rise(1, per);
        chk("R3 main period keeps old N", per + 10, 1024);
        wait_rise(1, per);
        chk("R3 main period uses new N", per, 1100);

        // R6: other codes pass the register through
        band_reg = 4'b1010;
        test_code = 3'b110;
        @(negedge clk);
        chk("R6 band pass in 110", int'(band_out), 10);

        // R11 control outputs
        os = 1'b1; cp = 1'b1;
        @(negedge clk);
        chk("R11 tune_en with os=1", int'(tune_en), 0);
        chk("R11 cp_hi with cp=1", int'(cp_hi), 1);
        os = 1'b0; cp = 1'b0;
        @(negedge clk);
        chk("R11 tune_en with os=0", int'(tune_en), 1);

        // R7: phase test, internal strobes ignored
        test_code = 3'b000;
        band_reg = 4'b0101;
        ext_ref = 1'b1; ext_div = 1'b1;
        @(negedge clk);
        ext_ref = 1'b0; ext_div = 1'b0;
        @(negedge clk);
        chk("R6 band pass in 000", int'(band_out), 5);
        begin
            int busy;
            busy = 0;
            for (int c = 0; c < 300; c++) begin
                @(negedge clk);
                if (pump_up || pump_dn) busy++;
            end
            chk("R7 internal strobes ignored", busy, 0);
        end

        // R8: reference first
        ext_ref = 1'b1;
        @(negedge clk);
        ext_ref = 1'b0;
        chk("R8 up after reference lead", int'(pump_up), 1);
        chk("R8 dn low on reference lead", int'(pump_dn), 0);
        repeat (3) @(negedge clk);
        chk("R8 up held until compare", int'(pump_up), 1);
        ext_div = 1'b1;
        @(negedge clk);
        ext_div = 1'b0;
        chk("R8 up cleared by compare", int'(pump_up), 0);

        // R8: compare first
        ext_div = 1'b1;
        @(negedge clk);
        ext_div = 1'b0;
        chk("R8 dn after compare lead", int'(pump_dn), 1);
        ext_ref = 1'b1;
        @(negedge clk);
        ext_ref = 1'b0;
        chk("R8 dn cleared by reference", int'(pump_dn), 0);

        // R8: coincident
        ext_ref = 1'b1; ext_div = 1'b1;
        @(negedge clk);
        ext_ref = 1'b0; ext_div = 1'b0;
        chk("R8 coincident gives no request", int'(pump_up | pump_dn), 0);

        // R9, R10: aligned loop, then a late divided strobe
        test_code = 3'b001;
        {rs_a, rs_b} = 2'b11;
        ratio_n = 15'd1024;
        xtal_tick = 1'b0;
        vco_tick = 1'b0;
        do_reset();
        saw_up = 1'b0;
        for (int k = 0; k < 6400; k++) begin
            skip = (k >= 6150 && k <= 6154) ? 1 : 0;
            xtal_tick = ((k % 16) == 15);
            vco_tick  = (k >= 15) && (skip == 0);
            @(negedge clk);
            if (k >= 6150 && pump_up) saw_up = 1'b1;
            if (k == 1000) chk("R9 not locked before four periods", int'(lock), 0);
            if (k == 5000) chk("R9 locked after aligned periods", int'(lock), 1);
            if (k == 6300) begin
                chk("R8 late compare gives up request", int'(saw_up), 1);
                chk("R10 wide pulse clears lock", int'(lock), 0);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule